// File: doc/BRIEF.md
# Automatic Status Polling Matcher

This block runs the repetitive part of waiting on an external flash device: it asks for a status read, takes the returned status byte, and checks it against a programmed reference value under a bit mask. A poll session starts when the enable input rises while the block is idle. From then on the block pulses a next-poll request. It waits for the status strobe, compares, and after a programmable gap of idle cycles it requests again. The serial transfer that fetches the status and the interface clock are handled elsewhere.

Two comparison rules are available. In the all-bits rule every compared bit must equal its reference bit. In the any-bit rule a single equal compared bit is enough. A match sets a sticky flag, which software clears with a write-one-to-clear pulse. The flag drives an interrupt through an enable. The session can end by itself on the first match, or keep running until it is aborted or enable is dropped. The rule and the stop choice are captured only while the block is idle, so a session always runs with one fixed setting.

Top module: `stat_poll_match`

## Requirements
- R1: With `any_mode` = 0 (all-bits rule), a status accepted while awaiting a response sets `match_flag` one cycle later only if every bit with `sts_mask` = 1 equals the same bit of `sts_match`.
- R2: With `any_mode` = 1 (any-bit rule), an accepted status sets `match_flag` when at least one bit with `sts_mask` = 1 equals its `sts_match` bit.
- R3: With `stop_on_match` = 0, polling goes on after matches, and ends only by `abort` or by `en` going low, with `busy` low the following cycle.
- R4: With `stop_on_match` = 1, a matching status ends the session: `busy` is low in the cycle after the strobe, and no further `poll_req` follows.
- R5: `any_mode` and `stop_on_match` are sampled only while `busy` is low. Changes made during a session do not affect that session.
- R6: `match_irq` is high exactly when `match_flag` and `match_ie` are both 1.
- R7: `match_flag` stays set until a `flag_clr` pulse. If a new match and `flag_clr` fall in the same cycle, the flag stays set.
- R8: `poll_req` is a one-cycle pulse. The first comes in the cycle after the rising `en` is sampled. After a non-stopping status strobe, exactly `poll_gap` cycles pass with neither the strobe nor the pulse, and then the pulse comes (`poll_gap` = 0 gives the pulse in the very next cycle).
- R9: A mask of all zeros never sets `match_flag`, under either rule.
- R10: `abort` brings `busy` low in the next cycle. A status strobe in the same cycle as `abort` is dropped and sets no flag.
- R11: A status strobe while no response is awaited (for example while idle) is ignored and leaves `match_flag` unchanged.
- R12: After reset, `busy`, `match_flag`, `match_irq` and `poll_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Enable; a rise while idle starts a session, low halts it |
| abort | input | 1 | Halts the session at once |
| sts_vld | input | 1 | Status byte valid strobe |
| sts_data | input | DW | Received status byte |
| sts_mask | input | DW | Compare mask, 1 = bit compared |
| sts_match | input | DW | Reference value |
| any_mode | input | 1 | 0 = all-bits rule, 1 = any-bit rule |
| stop_on_match | input | 1 | 1 = end session on first match |
| match_ie | input | 1 | Interrupt enable for the match flag |
| flag_clr | input | 1 | Write-one-to-clear pulse for the match flag |
| poll_gap | input | IW | Idle cycles between a status strobe and the next request |
| poll_req | output | 1 | One-cycle request for the next status read |
| match_flag | output | 1 | Sticky status-match flag |
| match_irq | output | 1 | Match interrupt |
| busy | output | 1 | A poll session is active |

## Verification
Two pairs of events can land in the same cycle. A fresh match can meet a clear pulse on the flag, and an incoming status strobe can meet an abort. The bench drives `flag_clr` high in the same cycle as a matching strobe and expects the flag to stay set. It also drives `abort` together with a matching strobe and expects `busy` low and the flag still clear on the next cycle. Both results are judged at the outputs by a scoreboard that predicts the match from its own bitwise model of the two rules.

// File: rtl/stat_poll_pkg.sv
`timescale 1ns/1ps
package stat_poll_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_REQ  = 2'd1,
    PS_RESP = 2'd2,
    PS_WAIT = 2'd3
  } poll_st_e;
endpackage

// File: rtl/stat_poll_cmp.sv
`timescale 1ns/1ps
module stat_poll_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] ref_v,
  input  logic          any_mode,
  output logic          hit
);
  logic [DW-1:0] same;

  // per-bit equality, one comparator per status bit
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign same[i] = ~(rx[i] ^ ref_v[i]);
  end

  logic all_ok, any_ok, mask_nz;
  assign all_ok  = &(same | ~mask);
  assign any_ok  = |(same & mask);
  assign mask_nz = |mask;

  always_comb begin
    if (any_mode) hit = any_ok;
    else          hit = all_ok & mask_nz;
  end
endmodule

// File: rtl/stat_poll_fsm.sv
`timescale 1ns/1ps
module stat_poll_fsm
  import stat_poll_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          halt,
  input  logic          rsp_vld,
  input  logic          hit,
  input  logic          stop_on_hit,
  input  logic [IW-1:0] gap,
  output logic          poll_req,
  output logic          busy,
  output logic          accept
);
  poll_st_e      st_q, st_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  assign accept   = (st_q == PS_RESP) & rsp_vld & ~halt;
  assign busy     = (st_q != PS_IDLE);
  assign poll_req = (st_q == PS_REQ);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    if (halt) begin
      st_d = PS_IDLE;
    end else begin
      unique case (st_q)
        PS_IDLE: if (start) st_d = PS_REQ;
        PS_REQ:  st_d = PS_RESP;
        PS_RESP: begin
          if (rsp_vld) begin
            if (hit && stop_on_hit) begin
              st_d = PS_IDLE;
            end else if (gap == '0) begin
              st_d = PS_REQ;
            end else begin
              st_d   = PS_WAIT;
              cnt_d  = gap - 1'b1;
              cnt_we = 1'b1;
            end
          end
        end
        PS_WAIT: begin
          if (cnt_q == '0) begin
            st_d = PS_REQ;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            cnt_we = 1'b1;
          end
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stat_poll_match.sv
`timescale 1ns/1ps
module stat_poll_match #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          abort,
  input  logic          sts_vld,
  input  logic [DW-1:0] sts_data,
  input  logic [DW-1:0] sts_mask,
  input  logic [DW-1:0] sts_match,
  input  logic          any_mode,
  input  logic          stop_on_match,
  input  logic          match_ie,
  input  logic          flag_clr,
  input  logic [IW-1:0] poll_gap,
  output logic          poll_req,
  output logic          match_flag,
  output logic          match_irq,
  output logic          busy
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rsync_q[SYNC_STAGES-1];

  logic en_q;
  logic mode_q, stop_q, cfg_we;
  logic hit, accept, start, halt;
  logic flag_q, flag_d, flag_set;

  assign start  = en & ~en_q;
  assign halt   = abort | ~en;
  assign cfg_we = ~busy;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) en_q <= 1'b0;
    else         en_q <= en;
  end

  // session settings captured only while idle
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= any_mode;
      stop_q <= stop_on_match;
    end
  end

  stat_poll_cmp #(.DW(DW)) u_cmp (
    .rx       (sts_data),
    .mask     (sts_mask),
    .ref_v    (sts_match),
    .any_mode (mode_q),
    .hit      (hit)
  );

  stat_poll_fsm #(.IW(IW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start       (start),
    .halt        (halt),
    .rsp_vld     (sts_vld),
    .hit         (hit),
    .stop_on_hit (stop_q),
    .gap         (poll_gap),
    .poll_req    (poll_req),
    .busy        (busy),
    .accept      (accept)
  );

  // sticky flag: a new match outranks a clear in the same cycle
  assign flag_set = accept & hit;
  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (flag_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign match_flag = flag_q;
  assign match_irq  = flag_q & match_ie;
endmodule

// File: rtl/stat_poll_match_chk.sv
`timescale 1ns/1ps
module stat_poll_match_chk (
  input logic clk,
  input logic rst_sn,
  input logic abort,
  input logic sts_vld,
  input logic flag_clr,
  input logic poll_req,
  input logic match_flag,
  input logic busy,
  input logic mode_q,
  input logic stop_q
);
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    abort |=> !busy);

  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    poll_req |=> !poll_req);

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |=> ($stable(mode_q) && $stable(stop_q)));

  // R7
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(match_flag) |-> $past(flag_clr));

  // R4
  stop_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(match_flag) && stop_q) |-> !busy);

  // R11
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(match_flag) |-> ($past(sts_vld) && !$past(abort)));
endmodule

bind stat_poll_match stat_poll_match_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .abort      (abort),
  .sts_vld    (sts_vld),
  .flag_clr   (flag_clr),
  .poll_req   (poll_req),
  .match_flag (match_flag),
  .busy       (busy),
  .mode_q     (mode_q),
  .stop_q     (stop_q)
);

// File: tb/stat_poll_match_test.sv
`timescale 1ns/1ps
module stat_poll_match_test;
  localparam int DW = 8;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n, en, abort, sts_vld, any_mode, stop_on_match, match_ie, flag_clr;
  logic [DW-1:0] sts_data, sts_mask, sts_match;
  logic [IW-1:0] poll_gap;
  logic          poll_req, match_flag, match_irq, busy;

  always #4 clk = ~clk;   // 125 MHz

  stat_poll_match #(.DW(DW), .IW(IW)) uut (.*);

  typedef struct {
    string      tag;
    logic [3:0] exp;   // {busy, flag, irq, req}
  } sb_item_t;

  sb_item_t sbq[$];
  int       n_chk = 0;
  int       n_bad = 0;
  bit       done  = 0;

  // bench model state
  logic flag_m, mode_m, stop_m;

  function automatic logic hit_ref(input logic anym, input logic [DW-1:0] m,
                                   input logic [DW-1:0] r, input logic [DW-1:0] d);
    int eq = 0, ne = 0;
    for (int i = 0; i < DW; i++) begin
      if (m[i]) begin
        if (d[i] == r[i]) eq++;
        else              ne++;
      end
    end
    if (anym) return (eq > 0);
    return (eq > 0) && (ne == 0);
  endfunction

  function automatic logic [3:0] vec(input logic b, input logic f, input logic r);
    return {b, f, f & match_ie, r};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string tag, input logic [3:0] e);
    sb_item_t it;
    it.tag = tag;
    it.exp = e;
    sbq.push_back(it);
  endtask

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      logic [3:0] act;
      it  = sbq.pop_front();
      act = {busy, match_flag, match_irq, poll_req};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  task automatic go(input string tag);
    en = 1'b0;
    cyc();
    mode_m = any_mode;
    stop_m = stop_on_match;
    en = 1'b1;
    cyc();
    push(tag, vec(1'b1, flag_m, 1'b1));
  endtask

  task automatic resp_phase(input string tag);
    cyc();
    push(tag, vec(1'b1, flag_m, 1'b0));
  endtask

  task automatic strobe(input logic [DW-1:0] d, input int gap, input string tag);
    logic h;
    h = hit_ref(mode_m, sts_mask, sts_match, d);
    sts_vld  = 1'b1;
    sts_data = d;
    cyc();
    sts_vld = 1'b0;
    if (h) flag_m = 1'b1;
    if (h && stop_m) begin
      push(tag, vec(1'b0, flag_m, 1'b0));
    end else if (gap == 0) begin
      push(tag, vec(1'b1, flag_m, 1'b1));
    end else begin
      push(tag, vec(1'b1, flag_m, 1'b0));
      repeat (gap - 1) begin
        cyc();
        push(tag, vec(1'b1, flag_m, 1'b0));
      end
      cyc();
      push(tag, vec(1'b1, flag_m, 1'b1));
    end
  endtask

  task automatic do_abort(input string tag);
    abort = 1'b1;
    cyc();
    abort = 1'b0;
    push(tag, vec(1'b0, flag_m, 1'b0));
  endtask

  task automatic do_clear(input string tag);
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
    flag_m = 1'b0;
    push(tag, vec(busy, 1'b0, poll_req));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; abort = 1'b0; sts_vld = 1'b0; sts_data = '0;
    sts_mask = 8'hF0; sts_match = 8'hA0; any_mode = 1'b0; stop_on_match = 1'b1;
    match_ie = 1'b1; flag_clr = 1'b0; poll_gap = 8'd2;
    flag_m = 1'b0; mode_m = 1'b0; stop_m = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) cyc();
    push("R12 reset", 4'b0000);
    cyc();

    // R11: strobe while idle is ignored
    sts_vld = 1'b1; sts_data = 8'hA5;
    cyc();
    sts_vld = 1'b0;
    push("R11 idle strobe", vec(1'b0, 1'b0, 1'b0));

    // R1/R8/R4/R6: all-bits rule, miss then hit with stop
    go("R8 first request");
    resp_phase("R8 resp");
    strobe(8'h5A, 2, "R1 miss R8 gap");
    resp_phase("R8 resp");
    strobe(8'hA3, 2, "R1 hit R4 stop R6 irq");
    do_clear("R7 clear");

    // R5: settings changed mid-session are not used
    go("R5 start");
    resp_phase("R5 resp");
    any_mode = 1'b1; stop_on_match = 1'b0;
    strobe(8'h80, 2, "R5 held all-bits rule");
    resp_phase("R5 resp");
    // R10: abort together with a matching strobe
    abort = 1'b1; sts_vld = 1'b1; sts_data = 8'hA0;
    cyc();
    abort = 1'b0; sts_vld = 1'b0;
    push("R10 abort drops strobe", vec(1'b0, flag_m, 1'b0));

    // R2/R3: any-bit rule, no stop
    go("R2 start");
    resp_phase("R2 resp");
    strobe(8'h80, 2, "R2 any hit R3 continue");
    resp_phase("R3 resp");
    strobe(8'h5F, 2, "R7 sticky R2 miss");
    resp_phase("R3 resp");
    en = 1'b0;
    cyc();
    push("R3 disable ends", vec(1'b0, flag_m, 1'b0));
    do_clear("R7 clear");

    // R7: set wins over clear in the same cycle
    go("R7 start");
    resp_phase("R7 resp");
    sts_vld = 1'b1; sts_data = 8'h80; flag_clr = 1'b1;
    cyc();
    sts_vld = 1'b0; flag_clr = 1'b0; flag_m = 1'b1;
    push("R7 set wins", vec(1'b1, 1'b1, 1'b0));
    do_abort("R10 abort in gap");
    do_clear("R7 clear");

    // R9: empty mask never matches in either rule
    sts_mask = 8'h00; any_mode = 1'b0; stop_on_match = 1'b1;
    go("R9 start");
    resp_phase("R9 resp");
    strobe(8'hA0, 2, "R9 all-bits empty mask");
    do_abort("R10 abort");
    any_mode = 1'b1;
    go("R9 start");
    resp_phase("R9 resp");
    strobe(8'hA0, 2, "R9 any-bit empty mask");
    do_abort("R10 abort");

    // R8 zero gap, R6 irq masked
    sts_mask = 8'hF0; any_mode = 1'b0; stop_on_match = 1'b1; poll_gap = 8'd0;
    go("R8 start");
    resp_phase("R8 resp");
    strobe(8'h5A, 0, "R8 zero gap");
    resp_phase("R8 resp");
    match_ie = 1'b0;
    strobe(8'hA0, 0, "R6 irq disabled R4 stop");

    repeat (2) cyc();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule